// File: doc/BRIEF.md
# Paged Buffer Memory Address Translator

This block sits between a network controller's 24-bit memory bus and a bank of on-board buffer RAM. The controller issues an address; the block looks the page number up in a page map and hands the memory side a physical address: a frame number with the 10-bit page offset appended. The top four address bits play no part in the lookup. The host and the controller work through the same map, so a buffer keeps the same physical page whichever side touches it.

Each map entry is one 16-bit word with three fields. The frame field gives the physical page. The order bit picks host byte order (lanes pass straight) or controller byte order (the two byte lanes of the 16-bit word are exchanged, together with their byte enables). The location bit routes the page either to on-board memory or to the auxiliary bus. Several slots may name the same frame. This is how the top slot, which covers the fixed boot structure near the top of the address space, is made to alias page 0.

The host loads and reads back entries through a 16-bit port indexed by slot number. The map is a dual-port memory with one port for the host and one for the lookup, so block RAM can be inferred.

Top module: `bufmap_xlate`

## Requirements
- R1: After reset, `out_valid`, `out_err` and `map_rvalid` are low, and `out_be` is zero, until a request or host read arrives.
- R2: For a request address A, the map slot is A[19:10] and the physical address is {entry[7:0], A[9:0]}; A[23:20] has no effect on any output.
- R3: A request presented at clock edge k produces its result in the cycle after edge k (one registered stage); with no request, `out_valid` and `out_err` stay low.
- R4: When entry bit 15 is 0, the write data leaves with its bytes exchanged (bits 15:8 and 7:0 trade places) and `out_be[1:0]` is exchanged the same way. When bit 15 is 1, data and enables pass unchanged.
- R5: `out_aux` equals entry bit 13 for a valid translation: 1 routes the page to the auxiliary bus, 0 to on-board memory.
- R6: If entry bits 11:8 are not all zero (frame 256 or above), the result shows `out_err` high, `out_valid` low and `out_be` zero.
- R7: Distinct slots may map to the same frame and then yield the same physical page; the top slot (1023) can map to frame 0, so address 0xFFFFF4 and address 0x0003F4 give the same physical address.
- R8: A host read of slot s (read enable high, write enable low) returns the full 16-bit stored entry on `map_rdata` with `map_rvalid` high in the following cycle.
- R9: A map write at edge k affects requests presented from edge k+1 onward. A request to the same slot at edge k still uses the previous entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_wr_en | input | 1 | Host writes map entry |
| map_rd_en | input | 1 | Host reads map entry |
| map_slot | input | 10 | Host slot index |
| map_wdata | input | 16 | Entry to store |
| map_rdata | output | 16 | Entry read back |
| map_rvalid | output | 1 | Read-back data valid |
| req_valid | input | 1 | Translation request |
| req_addr | input | 24 | Controller address |
| req_wdata | input | 16 | Write data in controller view |
| req_be | input | 2 | Byte enables in controller view |
| out_valid | output | 1 | Translation result valid |
| out_err | output | 1 | Frame out of range, access dropped |
| out_paddr | output | 18 | Physical buffer address |
| out_aux | output | 1 | Page lives on auxiliary bus |
| out_wdata | output | 16 | Write data after lane ordering |
| out_be | output | 2 | Byte enables after lane ordering |

## Verification
The bench targets the aliasing top slot. A design that used all 24 address bits, or that wrote the top slot in a special way, would give 0xFFFFF4 a different page from 0x0003F4. It drives writes and lookups to the same slot in the same cycle; a write-first memory would return the new entry one cycle early. It picks frame values just above 255; a design that truncated the frame without flagging it would silently reach a wrong page instead of dropping the access. It runs both order settings with one-sided byte enables; a design that swapped data but not enables would write the wrong byte.

// File: rtl/bufmap_pkg.sv
`timescale 1ns/1ps
package bufmap_pkg;
  // Entry field positions: hardware and host software both decode these.
  localparam int PTE_W        = 16;
  localparam int PTE_ORDER_B  = 15;  // 1: host order, lanes straight
  localparam int PTE_AUX_B    = 13;  // 1: auxiliary bus
  localparam int PTE_FRAME_W  = 12;  // frame field, bits 11:0

  typedef struct packed {
    logic                   straight;
    logic                   aux;
    logic [PTE_FRAME_W-1:0] frame;
  } pte_fields_t;

  function automatic pte_fields_t pte_decode(input logic [PTE_W-1:0] e);
    pte_fields_t f;
    f.straight = e[PTE_ORDER_B];
    f.aux      = e[PTE_AUX_B];
    f.frame    = e[PTE_FRAME_W-1:0];
    return f;
  endfunction
endpackage

// File: rtl/bufmap_ram.sv
`timescale 1ns/1ps
// Dual-port map store: port A host read/write, port B lookup read.
// Both reads are read-first, which keeps block RAM inference simple.
module bufmap_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) store[a_addr] <= a_wdata;
    a_rdata <= store[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= store[b_addr];
  end
endmodule

// File: rtl/bufmap_lane_swap.sv
`timescale 1ns/1ps
// Reverses lane order of a data word and its enables when swap is set.
module bufmap_lane_swap #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    swap,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic [LANES-1:0]        be_in,
  output logic [LANES*LANE_W-1:0] dout,
  output logic [LANES-1:0]        be_out
);
  logic [LANES*LANE_W-1:0] rev_d;
  logic [LANES-1:0]        rev_be;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rev_d[g*LANE_W +: LANE_W] = din[(LANES-1-g)*LANE_W +: LANE_W];
    assign rev_be[g]                 = be_in[LANES-1-g];
  end

  assign dout   = swap ? rev_d  : din;
  assign be_out = swap ? rev_be : be_in;
endmodule

// File: rtl/bufmap_xlate.sv
`timescale 1ns/1ps
module bufmap_xlate
  import bufmap_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int SLOT_W  = 10,
  parameter int OFS_W   = 10,
  parameter int FRAME_W = 8,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      map_wr_en,
  input  logic                      map_rd_en,
  input  logic [SLOT_W-1:0]         map_slot,
  input  logic [PTE_W-1:0]          map_wdata,
  output logic [PTE_W-1:0]          map_rdata,
  output logic                      map_rvalid,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [LANES*LANE_W-1:0]   req_wdata,
  input  logic [LANES-1:0]          req_be,
  output logic                      out_valid,
  output logic                      out_err,
  output logic [FRAME_W+OFS_W-1:0]  out_paddr,
  output logic                      out_aux,
  output logic [LANES*LANE_W-1:0]   out_wdata,
  output logic [LANES-1:0]          out_be
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int HI_W   = PTE_FRAME_W - FRAME_W;  // frame bits that must be zero

  // Lookup port: slot is taken from the address; the bits above it are unused.
  logic [SLOT_W-1:0] look_slot;
  logic [PTE_W-1:0]  pte_q;
  assign look_slot = req_addr[OFS_W +: SLOT_W];

  bufmap_ram #(.ADDR_W(SLOT_W), .DATA_W(PTE_W)) u_map (
    .clk     (clk),
    .a_we    (map_wr_en),
    .a_addr  (map_slot),
    .a_wdata (map_wdata),
    .a_rdata (map_rdata),
    .b_addr  (look_slot),
    .b_rdata (pte_q)
  );

  always_ff @(posedge clk) begin
    if (rst) map_rvalid <= 1'b0;
    else     map_rvalid <= map_rd_en & ~map_wr_en;
  end

  // Request side fields travel alongside the map read.
  logic              v_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] wd_q;
  logic [LANES-1:0]  be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      ofs_q <= '0;
      wd_q  <= '0;
      be_q  <= '0;
    end else begin
      v_q   <= req_valid;
      ofs_q <= req_addr[OFS_W-1:0];
      wd_q  <= req_wdata;
      be_q  <= req_be;
    end
  end

  pte_fields_t fld;
  logic        frame_bad;
  assign fld = pte_decode(pte_q);

  if (HI_W > 0) begin : g_range
    assign frame_bad = |fld.frame[PTE_FRAME_W-1:FRAME_W];
  end else begin : g_norange
    assign frame_bad = 1'b0;
  end

  logic [DATA_W-1:0] sw_d;
  logic [LANES-1:0]  sw_be;

  bufmap_lane_swap #(.LANES(LANES), .LANE_W(LANE_W)) u_swap (
    .swap   (~fld.straight),
    .din    (wd_q),
    .be_in  (be_q),
    .dout   (sw_d),
    .be_out (sw_be)
  );

  assign out_valid = v_q & ~frame_bad;
  assign out_err   = v_q & frame_bad;
  assign out_paddr = {fld.frame[FRAME_W-1:0], ofs_q};
  assign out_aux   = out_valid & fld.aux;
  assign out_wdata = sw_d;
  assign out_be    = out_valid ? sw_be : '0;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !out_err)); // R3
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (out_valid ^ out_err)); // R3
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (out_paddr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0]))); // R2
  AST_BE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $countones(req_be) == 1) |=> (out_err || $countones(out_be) == 1)); // R4
  AST_ERR_NO_BE: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_be == '0 && !out_aux)); // R6
  AST_READBACK_VALID: assert property (@(posedge clk) disable iff (rst)
    (map_rd_en && !map_wr_en) |=> map_rvalid); // R8
endmodule

// File: tb/bufmap_xlate_tb_top.sv
`timescale 1ns/1ps
module bufmap_xlate_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        map_wr_en = 0, map_rd_en = 0;
  logic [9:0]  map_slot = 0;
  logic [15:0] map_wdata = 0;
  logic [15:0] map_rdata;
  logic        map_rvalid;
  logic        req_valid = 0;
  logic [23:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [1:0]  req_be = 0;
  logic        out_valid, out_err, out_aux;
  logic [17:0] out_paddr;
  logic [15:0] out_wdata;
  logic [1:0]  out_be;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] model [1024];

  always #2 clk = ~clk;

  bufmap_xlate dut_i (
    .clk(clk), .rst(rst),
    .map_wr_en(map_wr_en), .map_rd_en(map_rd_en), .map_slot(map_slot),
    .map_wdata(map_wdata), .map_rdata(map_rdata), .map_rvalid(map_rvalid),
    .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .out_valid(out_valid), .out_err(out_err), .out_paddr(out_paddr), .out_aux(out_aux),
    .out_wdata(out_wdata), .out_be(out_be)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected result of one translation, built from the requirements.
  task automatic check_xlate(input logic [15:0] pte, input logic [23:0] a,
                             input logic [15:0] d, input logic [1:0] be, input string req);
    bit bad = (pte[11:8] != 4'h0);
    logic [15:0] ed = pte[15] ? d : {d[7:0], d[15:8]};
    logic [1:0]  eb = pte[15] ? be : {be[0], be[1]};
    chk({req, " err"},   {31'd0, out_err},   {31'd0, bad});
    chk({req, " valid"}, {31'd0, out_valid}, {31'd0, !bad});
    if (bad) begin
      chk({req, " R6 be"}, {30'd0, out_be}, 32'd0);
    end else begin
      chk({req, " R2 paddr"}, {14'd0, out_paddr}, {14'd0, pte[7:0], a[9:0]});
      chk({req, " R5 aux"},   {31'd0, out_aux},   {31'd0, pte[13]});
      chk({req, " R4 data"},  {16'd0, out_wdata}, {16'd0, ed});
      chk({req, " R4 be"},    {30'd0, out_be},    {30'd0, eb});
    end
  endtask

  task automatic map_write(input logic [9:0] s, input logic [15:0] v);
    @(negedge clk);
    map_wr_en = 1; map_slot = s; map_wdata = v;
    @(negedge clk);
    map_wr_en = 0;
    model[s] = v;
  endtask

  task automatic map_read(input logic [9:0] s);
    @(negedge clk);
    map_rd_en = 1; map_slot = s;
    @(posedge clk); #1;
    chk("R8 rvalid", {31'd0, map_rvalid}, 32'd1);
    chk("R8 rdata", {16'd0, map_rdata}, {16'd0, model[s]});
    @(negedge clk);
    map_rd_en = 0;
  endtask

  task automatic xlate(input logic [23:0] a, input logic [15:0] d, input logic [1:0] be,
                       input string req);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk); #1;
    check_xlate(model[a[19:10]], a, d, be, req);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] old;
    logic [15:0] nv;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 out_valid", {31'd0, out_valid}, 0);
    chk("R1 out_err", {31'd0, out_err}, 0);
    chk("R1 map_rvalid", {31'd0, map_rvalid}, 0);
    chk("R1 out_be", {30'd0, out_be}, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk("R1 idle valid", {31'd0, out_valid}, 0);
    chk("R3 idle err", {31'd0, out_err}, 0);

    // Direct map, top slot aliased to frame 0, host order.
    for (int i = 0; i < 1023; i++) map_write(i[9:0], 16'h8000 | 16'(i & 255));
    map_write(10'd1023, 16'h8000);

    // R7: boot pointer alias and shared frame
    xlate(24'hFFFFF4, 16'h1234, 2'b11, "R7 top slot");
    chk("R7 alias page0", {14'd0, out_paddr}, {14'd0, 8'h00, 10'h3F4});
    xlate(24'h0003F4, 16'h1234, 2'b11, "R7 slot0");
    chk("R7 alias same", {14'd0, out_paddr}, {14'd0, 8'h00, 10'h3F4});
    map_write(10'd5, 16'h8011);
    map_write(10'd900, 16'h8011);
    xlate({4'h0, 10'd5, 10'h07F}, 16'hAAAA, 2'b11, "R7 shared a");
    xlate({4'h0, 10'd900, 10'h07F}, 16'hAAAA, 2'b11, "R7 shared b");
    chk("R7 shared frame", {14'd0, out_paddr}, {14'd0, 8'h11, 10'h07F});

    // R2: top nibble ignored
    xlate({4'hF, 10'd77, 10'h155}, 16'h0F0F, 2'b01, "R2 top nibble F");
    xlate({4'h0, 10'd77, 10'h155}, 16'h0F0F, 2'b01, "R2 top nibble 0");

    // R4/R5: controller order and aux bus, one-sided enables
    map_write(10'd12, 16'h2033);
    xlate({4'h3, 10'd12, 10'h002}, 16'hBEEF, 2'b01, "R4 swap lo");
    xlate({4'h0, 10'd12, 10'h3FF}, 16'hBEEF, 2'b10, "R4 swap hi");
    map_write(10'd13, 16'hA0FE);
    xlate({4'h0, 10'd13, 10'h000}, 16'hC0DE, 2'b10, "R5 aux straight");

    // R6: frame just above range
    map_write(10'd14, 16'h8100);
    xlate({4'h0, 10'd14, 10'h010}, 16'h5555, 2'b11, "R6 frame 256");
    map_write(10'd15, 16'h0FFF);
    xlate({4'h0, 10'd15, 10'h010}, 16'h5555, 2'b01, "R6 frame FFF");

    // R8: full-width readback including unused bits
    map_write(10'd20, 16'h5ABC);
    map_read(10'd20);
    map_read(10'd1023);

    // R9: write and lookup of the same slot in one cycle
    old = model[30];
    nv  = 16'h2042;
    @(negedge clk);
    map_wr_en = 1; map_slot = 10'd30; map_wdata = nv;
    req_valid = 1; req_addr = {4'h0, 10'd30, 10'h123}; req_wdata = 16'h1357; req_be = 2'b11;
    @(posedge clk); #1;
    check_xlate(old, req_addr, 16'h1357, 2'b11, "R9 same cycle old");
    @(negedge clk);
    map_wr_en = 0; req_valid = 0;
    model[30] = nv;
    xlate({4'h0, 10'd30, 10'h123}, 16'h1357, 2'b11, "R9 next cycle new");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [9:0] s;
      s = 10'($urandom_range(0, 1023));
      if ($urandom_range(0, 3) == 0) begin
        logic [15:0] e;
        e = 16'($urandom);
        if ($urandom_range(0, 2) != 0) e[11:8] = 4'h0;
        map_write(s, e);
      end
      if ($urandom_range(0, 7) == 0) map_read(s);
      xlate({4'($urandom), s, 10'($urandom)}, 16'($urandom), 2'($urandom), "R2 R4 R5 R6 random");
    end

    @(posedge clk); #1;
    chk("R3 idle after run", {31'd0, out_valid | out_err}, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule